// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three 16-bit down-counters behind a byte-wide register port. A shared control register picks one counter, then either snapshots its count or sets its counting mode. Each counter has its own data address. Counts are written and read as a low byte followed by a high byte. All counting advances only on cycles where the timebase enable `tick_i` is high. That enable is expected at about 1.193 MHz.

Each counter runs in one of three modes. In terminal-count mode the output rises once. In rate-generator mode the output gives a one-tick low pulse once per period. In square-wave mode the output is high for half the period and low for the other half. The output of counter 2 can also be read as a status bit at a separate system-control address.

The port addresses are:
- 0 to 2: counter data
- 3: control word
- 4: system control

Top module: `pit_timer`

## Requirements
- R1: After reset, `out_o` is 0 and `cfg_err_o` is 0. Every counter reads back a count of 0 and is in terminal-count mode.
- R2: The control word (address 3) has four fields: select in bits 7:6, access field in bits 5:4, mode in bits 3:1 and BCD in bit 0. A word is rejected in any of these cases:
  - select is 3;
  - the access field is 01 or 10;
  - the access field is 11 and the mode is not 0, 2 or 3;
  - the access field is 11 and the BCD bit is 1.
  A rejected word raises `cfg_err_o` for one cycle, starting the cycle after the write, and changes no counter. Access 11 with mode 0, 2 or 3 sets that counter's mode; mode 0 is terminal count, 2 is rate generator and 3 is square wave.
- R3: An access field of 00 is a latch command. If no snapshot is pending, it copies the live count into a snapshot and points the read sequence at the low byte. If a snapshot is already pending, the command is ignored.
- R4: While a snapshot is pending, the next two data reads return its low byte and then its high byte. The high-byte read releases the snapshot.
- R5: With no snapshot pending, data reads alternate between the low byte and the high byte of the live count, starting with the low byte.
- R6: The first data write of a pair replaces the low byte of the count. It also stops the counter and drives its output low.
- R7: The second data write replaces the high byte and copies the full count into the period register. The counter starts only if that 16-bit value is nonzero. On start, the output is high in modes 2 and 3 and stays low in mode 0.
- R8: In mode 0, with count N, the output goes high on the N-th tick, the count stops at 0, and the output stays high until the next low-byte write.
- R9: In rate-generator mode with period N ≥ 2, the output after k ticks is low exactly when k mod N = N-1. The count reloads from the period on the tick where it reaches 1.
- R10: In square-wave mode with period N ≥ 2:
  - the counter starts at N - floor(N/2);
  - the output is high for N - floor(N/2) ticks, then low for floor(N/2) ticks, and repeats.
- R11: A read of address 4 returns bit 5 equal to the output of counter 2, with every other bit 0. A write to address 4 has no effect.
- R12: Read data appears on `rdata_o` in the cycle after the `rd_i` strobe. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counting timebase enable |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| out_o | output | 3 | Counter outputs |
| cfg_err_o | output | 1 | Rejected control word pulse |

## Verification
Each result has a fixed due cycle:
- A read result is due one cycle after its strobe.
- A rejected control word raises `cfg_err_o` one cycle after the write.
- A counter output changes one cycle after the clock edge that carries the write or the tick.

Every stimulus task drives inputs on the falling edge and holds them through exactly one rising edge. It then samples on the next falling edge, so each check lands in the cycle where its result is due. Output waveforms are compared tick by tick against bench functions of the period and the tick index.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    CM_TERM   = 2'd0,
    CM_RATE   = 2'd1,
    CM_SQUARE = 2'd2
  } cnt_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [1:0]       acc;
    logic [2:0]       mode;
    logic             bcd;
  } ctrl_word_t;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_PAIR  = 2'b11;
endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
  import pit_pkg::*;
#(
  parameter int NUM_CNT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [NUM_CNT-1:0] latch_o,
  output logic [NUM_CNT-1:0] cfg_o,
  output cnt_mode_e          mode_o,
  output logic               err_o
);
  ctrl_word_t cw;
  logic sel_ok, mode_ok, is_latch, is_pair, bad;

  assign cw       = ctrl_word_t'(wdata_i);
  assign sel_ok   = int'(cw.sel) < NUM_CNT;
  assign is_latch = cw.acc == ACC_LATCH;
  assign is_pair  = cw.acc == ACC_PAIR;

  always_comb begin
    mode_ok = 1'b1;
    mode_o  = CM_TERM;
    case (cw.mode)
      3'd0:    mode_o = CM_TERM;
      3'd2:    mode_o = CM_RATE;
      3'd3:    mode_o = CM_SQUARE;
      default: mode_ok = 1'b0;
    endcase
  end

  assign bad = wr_i && (!sel_ok || (!is_latch && (!is_pair || !mode_ok || cw.bcd)));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_strb
    assign latch_o[i] = wr_i && !bad && is_latch && (cw.sel == SEL_W'(i));
    assign cfg_o[i]   = wr_i && !bad && is_pair  && (cw.sel == SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= bad;
  end

  // R2
  ctrl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({latch_o, cfg_o}));
  // R2
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i) && $past(latch_o) == '0 && $past(cfg_o) == '0);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              latch_i,
  input  logic              cfg_i,
  input  cnt_mode_e         mode_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rbyte_o,
  output logic              out_o
);
  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] count_q, period_q, latched_q;
  logic          latch_on_q, rd_hi_q, wr_hi_q, run_q, out_q;
  cnt_mode_e     mode_q;

  logic [CW-1:0] full_load, half_lo, lo_len, hi_len, src;

  assign full_load = {wdata_i, count_q[DATA_W-1:0]};
  assign half_lo   = period_q >> 1;
  assign lo_len    = (half_lo == '0) ? CW'(1) : half_lo;
  assign hi_len    = period_q - half_lo;
  assign src       = latch_on_q ? latched_q : count_q;
  assign rbyte_o   = rd_hi_q ? src[CW-1:DATA_W] : src[DATA_W-1:0];
  assign out_o     = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q    <= '0;
      period_q   <= '0;
      latched_q  <= '0;
      latch_on_q <= 1'b0;
      rd_hi_q    <= 1'b0;
      wr_hi_q    <= 1'b0;
      run_q      <= 1'b0;
      out_q      <= 1'b0;
      mode_q     <= CM_TERM;
    end else begin
      if (cfg_i) mode_q <= mode_i;

      // snapshot and read sequencing
      if (latch_i) begin
        if (!latch_on_q) begin
          latch_on_q <= 1'b1;
          rd_hi_q    <= 1'b0;
          latched_q  <= count_q;
        end
      end else if (rd_i) begin
        rd_hi_q <= !rd_hi_q;
        if (latch_on_q && rd_hi_q) latch_on_q <= 1'b0;
      end

      // load or count
      if (wr_i) begin
        if (!wr_hi_q) begin
          count_q[DATA_W-1:0] <= wdata_i;
          run_q   <= 1'b0;
          out_q   <= 1'b0;
          wr_hi_q <= 1'b1;
        end else begin
          wr_hi_q  <= 1'b0;
          period_q <= full_load;
          run_q    <= full_load != '0;
          out_q    <= (full_load != '0) && (mode_q != CM_TERM);
          if (mode_q == CM_SQUARE && full_load != '0)
            count_q <= full_load - (full_load >> 1);
          else
            count_q <= full_load;
        end
      end else if (run_q && tick_i) begin
        case (mode_q)
          CM_TERM: begin
            count_q <= count_q - 1'b1;
            if (count_q == CW'(1)) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
          CM_RATE: begin
            if (count_q == CW'(1)) begin
              count_q <= period_q;
              out_q   <= 1'b1;
            end else begin
              count_q <= count_q - 1'b1;
              out_q   <= count_q != CW'(2);
            end
          end
          default: begin
            if (count_q == CW'(1)) begin
              out_q   <= !out_q;
              count_q <= out_q ? lo_len : hi_len;
            end else begin
              count_q <= count_q - 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R6
  lsb_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_hi_q |=> !run_q && !out_q);
  // R7
  zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_hi_q && full_load == '0 |=> !run_q);
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_on_q && !rd_i |=> latch_on_q && $stable(latched_q));
  // R8
  term_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == CM_TERM && out_q && !wr_i |=> out_q);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int SPK_CNT = 2,
  parameter int SPK_BIT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_CNT-1:0] out_o,
  output logic               cfg_err_o
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] ADDR_SYS  = ADDR_W'(NUM_CNT + 1);

  logic [NUM_CNT-1:0] latch_s, cfg_s;
  cnt_mode_e          mode_s;
  logic [DATA_W-1:0]  rbyte [NUM_CNT];
  logic [DATA_W-1:0]  rd_byte;

  pit_ctrl_dec #(.NUM_CNT(NUM_CNT)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && addr_i == ADDR_CTRL),
    .wdata_i (wdata_i),
    .latch_o (latch_s),
    .cfg_o   (cfg_s),
    .mode_o  (mode_s),
    .err_o   (cfg_err_o)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pit_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .latch_i (latch_s[i]),
      .cfg_i   (cfg_s[i]),
      .mode_i  (mode_s),
      .wr_i    (wr_i && addr_i == ADDR_W'(i)),
      .rd_i    (rd_i && addr_i == ADDR_W'(i)),
      .wdata_i (wdata_i),
      .rbyte_o (rbyte[i]),
      .out_o   (out_o[i])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (addr_i == ADDR_W'(i)) rd_byte = rbyte[i];
    if (addr_i == ADDR_SYS) rd_byte[SPK_BIT] = out_o[SPK_CNT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_byte;
  end

  // R11
  spk_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_SYS |=> rdata_o[SPK_BIT] == $past(out_o[SPK_CNT]) && $countones(rdata_o) <= 1);
  // R12
  ctrl_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_CTRL |=> rdata_o == '0);
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] outs;
  logic       err;
  int         checks = 0, errors = 0;
  int unsigned seed_sink;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pit_timer u_pit_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .out_o(outs), .cfg_err_o(err)
  );

  function automatic bit exp_term(int k, int n);  return k >= n; endfunction
  function automatic bit exp_rate(int k, int n);  return (k % n) != (n - 1); endfunction
  function automatic bit exp_square(int k, int n);
    int hi = n - n / 2;
    int lo = (n / 2 < 1) ? 1 : n / 2;
    return (k % (hi + lo)) < hi;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ctrl(input int sel, input int acc, input int mode, input int bcd);
    bus_wr(3'd3, {sel[1:0], acc[1:0], mode[2:0], bcd[0]});
  endtask

  task automatic load(input int sel, input logic [15:0] v);
    bus_wr(3'(sel), v[7:0]);
    bus_wr(3'(sel), v[15:8]);
  endtask

  task automatic rd16(input int sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_rd(3'(sel), lo);
    bus_rd(3'(sel), hi);
    v = {hi, lo};
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v, exp16;
    logic [7:0]  b;
    seed_sink = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(outs == 3'b000 && err == 1'b0, "R1 outputs", {outs, err}, 0);
    rd16(0, v); chk(v == 16'h0, "R1 count", v, 0);

    // R5 R7 random load and live readback
    for (int i = 0; i < 20; i++) begin
      int sel = $urandom_range(0, 2);
      exp16 = 16'($urandom);
      ctrl(sel, 3, 0, 0);
      chk(err == 1'b0, "R2 valid word", err, 0);
      load(sel, exp16);
      rd16(sel, v); chk(v == exp16, "R5 live readback", v, exp16);
    end

    // R2 rejected words
    ctrl(3, 3, 0, 0); chk(err, "R2 select 3", err, 1);
    @(negedge clk);   chk(!err, "R2 one-cycle pulse", err, 0);
    ctrl(0, 1, 0, 0); chk(err, "R2 access 01", err, 1);
    ctrl(0, 3, 1, 0); chk(err, "R2 mode 1", err, 1);
    ctrl(0, 3, 6, 0); chk(err, "R2 mode 6", err, 1);
    ctrl(0, 3, 0, 0);
    ctrl(0, 3, 2, 1); chk(err, "R2 bcd", err, 1);
    load(0, 16'd3); do_tick();
    chk(outs[0] == 1'b0, "R2 rejected word left mode 0", outs[0], 0);

    // R6 low byte write stops counter
    ctrl(0, 3, 0, 0); load(0, 16'd10);
    do_tick(); do_tick();
    bus_wr(3'd0, 8'h55);
    chk(outs[0] == 1'b0, "R6 out low", outs[0], 0);
    repeat (4) do_tick();
    rd16(0, v); chk(v == 16'h0055, "R6 stopped count", v, 16'h0055);
    bus_wr(3'd0, 8'h00);

    // R7 zero load does not start
    ctrl(1, 3, 2, 0); load(1, 16'd0);
    repeat (3) do_tick();
    chk(outs[1] == 1'b0, "R7 zero stays idle", outs[1], 0);
    rd16(1, v); chk(v == 16'd0, "R7 zero count", v, 0);

    // R8 mode 0
    for (int r = 0; r < 4; r++) begin
      int n = $urandom_range(2, 30);
      ctrl(0, 3, 0, 0); load(0, 16'(n));
      chk(outs[0] == 1'b0, "R7 mode0 start low", outs[0], 0);
      for (int k = 1; k <= n + 3; k++) begin
        do_tick();
        chk(outs[0] == exp_term(k, n), "R8 terminal", outs[0], exp_term(k, n));
      end
      rd16(0, v); chk(v == 16'd0, "R8 stopped at 0", v, 0);
    end

    // R9 rate generator
    for (int r = 0; r < 4; r++) begin
      int n = $urandom_range(2, 12);
      ctrl(1, 3, 2, 0); load(1, 16'(n));
      chk(outs[1] == 1'b1, "R7 mode2 start high", outs[1], 1);
      for (int k = 1; k <= 3 * n; k++) begin
        do_tick();
        chk(outs[1] == exp_rate(k, n), "R9 rate", outs[1], exp_rate(k, n));
      end
    end

    // R10 square wave, odd and even periods, on counter 2 with speaker port
    for (int r = 0; r < 4; r++) begin
      int n = (r == 0) ? 2 : (r == 1) ? 7 : $urandom_range(3, 12);
      ctrl(2, 3, 3, 0); load(2, 16'(n));
      rd16(2, v); chk(v == 16'(n - n / 2), "R10 start count", v, n - n / 2);
      for (int k = 1; k <= 3 * n; k++) begin
        do_tick();
        chk(outs[2] == exp_square(k, n), "R10 square", outs[2], exp_square(k, n));
        if (k % 3 == 0) begin
          bus_rd(3'd4, b);
          chk(b == {2'b00, exp_square(k, n), 5'b0}, "R11 speaker bit", b, {2'b00, exp_square(k, n), 5'b0});
        end
      end
    end

    // R11 speaker in mode 0, write to port ignored
    ctrl(2, 3, 0, 0); load(2, 16'd4);
    bus_rd(3'd4, b); chk(b == 8'h00, "R11 speaker low", b, 0);
    bus_wr(3'd4, 8'hFF);
    repeat (4) do_tick();
    bus_rd(3'd4, b); chk(b == 8'h20, "R11 speaker high", b, 8'h20);
    bus_wr(3'd4, 8'h00);
    bus_rd(3'd4, b); chk(b == 8'h20, "R11 write ignored", b, 8'h20);

    // R12 control address reads zero
    bus_rd(3'd3, b); chk(b == 8'h00, "R12 ctrl read", b, 0);

    // R3 R4 latch behaviour
    ctrl(1, 3, 0, 0); load(1, 16'd1000);
    ctrl(1, 0, 0, 0);
    repeat (3) do_tick();
    ctrl(1, 0, 5, 1);
    chk(err == 1'b0, "R3 latch ignores other fields", err, 0);
    repeat (2) do_tick();
    rd16(1, v); chk(v == 16'd1000, "R4 latched value", v, 1000);
    rd16(1, v); chk(v == 16'd995, "R3 second latch ignored, R4 released", v, 995);
    ctrl(1, 0, 0, 0); do_tick();
    bus_rd(3'd1, b); chk(b == 8'(16'd995), "R4 latched lsb", b, 8'(16'd995));
    do_tick();
    bus_rd(3'd1, b); chk(b == 8'(16'd995 >> 8), "R4 latched msb", b, 8'(16'd995 >> 8));
    rd16(1, v); chk(v == 16'd993, "R5 live after release", v, 993);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule